// File: doc/BRIEF.md
# Rename History Log with Squash Rollback and Commit Retirement

This block keeps an ordered log of destination-register renames for one hardware thread. The rename stage writes one record for each destination operand it renames. A record holds the instruction's sequence number, the architectural register, the physical register just allocated to it, and the physical register that was mapped to it before. One instruction with several destinations writes several records that share a sequence number.

The log serves two release walks that move in opposite directions:

- **Squash undo.** It starts at the youngest record. For each record it points the map table back at the earlier physical register and returns the new physical register to the free list. A new register in the miscellaneous range is also marked ready in the scoreboard.
- **Commit retirement.** It starts at the oldest record and returns the earlier physical register of each retired record to the free list.

Each walk retires at most one record per clock. `busy` stays high while a walk runs. New walk requests are not accepted during that time.

Records enter through a valid/ready stream. `rec_ready` is high exactly when no walk runs. A record transfers on a cycle where `rec_valid` and `rec_ready` are both high. A source that sees `rec_ready` low must hold its record. The squash and commit inputs are plain control: a request presented while `busy` is high is ignored, not queued. The three release outputs are one-cycle write strobes with no back-pressure, because the map table, free list and scoreboard always take a write.

Top module: `rename_history_log`

## Requirements
- R1: After reset the log is empty, `busy`, `overflow` and all release strobes are low, and `rec_ready` is high.
- R2: `rec_ready` equals the inverse of `busy`. An accepted record is appended at the young end of the log, and several records may carry the same sequence number.
- R3: A record accepted while the log already holds DEPTH records is dropped. `overflow` pulses high for exactly one cycle, in the cycle after the transfer, and the log contents are unchanged.
- R4: A squash is accepted when `sq_valid` is high and `busy` is low. It removes records youngest-first while the record's sequence number is strictly greater than `sq_seq`. For each removed record, one cycle carries `map_wr_valid` with (architectural register, previous physical register) together with `free_valid` carrying the new physical register.
- R5: During a squash undo, a removed record whose new physical register index is at or above NONMISC_PREGS also raises `sb_set_valid` with that register, in the same cycle as its map write. Below that bound, `sb_set_valid` stays low.
- R6: A commit removes records oldest-first while the sequence number is less than or equal to `done_seq`. Each removal gives one `free_valid` strobe carrying the previous physical register, with `map_wr_valid` and `sb_set_valid` low.
- R7: A commit starts only when `busy` is low, `done_seq` is non-zero, `sq_valid` is low and `thread_squashing` is low. When a squash and a commit are requested together, only the squash runs.
- R8: A squash or commit that finds no record to remove is legal. `busy` is high for one cycle and no strobe is issued.
- R9: A walk removing k records keeps `busy` high for k+1 consecutive cycles, issues one strobe per cycle on consecutive cycles, and ignores squash and commit requests that arrive while it runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_valid | input | 1 | Rename record offered |
| rec_ready | output | 1 | Record can be taken (no walk running) |
| rec_seq | input | SEQ_W | Sequence number of the renamed instruction |
| rec_areg | input | AREG_W | Architectural destination register |
| rec_new_preg | input | PREG_W | Newly allocated physical register |
| rec_prev_preg | input | PREG_W | Physical register mapped before the rename |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Youngest sequence number that survives the squash |
| done_seq | input | SEQ_W | Youngest committed sequence number (zero means none) |
| thread_squashing | input | 1 | Thread is in the squashing state; blocks commit |
| busy | output | 1 | A walk is in progress |
| overflow | output | 1 | One-cycle pulse: a record was dropped because the log was full |
| map_wr_valid | output | 1 | Map-table restore strobe |
| map_wr_areg | output | AREG_W | Architectural register to restore |
| map_wr_preg | output | PREG_W | Physical register to restore into the map |
| free_valid | output | 1 | Free-list return strobe |
| free_preg | output | PREG_W | Physical register returned to the free list |
| sb_set_valid | output | 1 | Scoreboard ready-set strobe |
| sb_set_preg | output | PREG_W | Physical register marked ready |

## Verification
Problems in the pointers or the occupancy count show up directly at the ports:

- A mis-stepped young or old pointer restores the wrong register pair. This is visible on the first strobe of the next walk, two cycles after the request.
- A wrong occupancy count does one of three things: it stretches or shortens the `busy` window against the k+1 cycles expected, it issues strobes for records that were never written, or it misplaces the `overflow` pulse in the cycle after the extra record.

A walker that compares sequence numbers in the wrong sense either removes one record too many or stops one too early. The bench sees this at the end of that same walk, as a missing or extra strobe and a `busy` length off by one.

// File: rtl/rhl_pkg.sv
package rhl_pkg;
  typedef enum logic [1:0] {
    WALK_IDLE   = 2'd0,
    WALK_UNDO   = 2'd1,
    WALK_RETIRE = 2'd2
  } walk_e;
endpackage

// File: rtl/rhl_ring.sv
module rhl_ring #(
  parameter int DEPTH  = 16,
  parameter int SEQ_W  = 16,
  parameter int AREG_W = 6,
  parameter int PREG_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [SEQ_W-1:0]  push_seq,
  input  logic [AREG_W-1:0] push_areg,
  input  logic [PREG_W-1:0] push_new,
  input  logic [PREG_W-1:0] push_prev,
  input  logic              pop_young,
  input  logic              pop_old,
  output logic              full,
  output logic              empty,
  output logic [SEQ_W-1:0]  young_seq,
  output logic [AREG_W-1:0] young_areg,
  output logic [PREG_W-1:0] young_new,
  output logic [PREG_W-1:0] young_prev,
  output logic [SEQ_W-1:0]  old_seq,
  output logic [PREG_W-1:0] old_prev
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [SEQ_W-1:0]  seq_mem  [DEPTH];
  logic [AREG_W-1:0] areg_mem [DEPTH];
  logic [PREG_W-1:0] new_mem  [DEPTH];
  logic [PREG_W-1:0] prev_mem [DEPTH];

  logic [PTR_W-1:0] head_q, tail_q, young_idx;
  logic [CNT_W-1:0] cnt_q;
  logic             wr_en;

  function automatic logic [PTR_W-1:0] step_up(input logic [PTR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PTR_W-1:0] step_dn(input logic [PTR_W-1:0] p);
    return (p == '0) ? LAST_IDX : p - 1'b1;
  endfunction

  assign full      = (cnt_q == FULL_CNT);
  assign empty     = (cnt_q == '0);
  assign wr_en     = push && !full;
  assign young_idx = step_dn(tail_q);

  assign young_seq  = seq_mem[young_idx];
  assign young_areg = areg_mem[young_idx];
  assign young_new  = new_mem[young_idx];
  assign young_prev = prev_mem[young_idx];
  assign old_seq    = seq_mem[head_q];
  assign old_prev   = prev_mem[head_q];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      seq_mem[tail_q]  <= push_seq;
      areg_mem[tail_q] <= push_areg;
      new_mem[tail_q]  <= push_new;
      prev_mem[tail_q] <= push_prev;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_en) begin
        tail_q <= step_up(tail_q);
        cnt_q  <= cnt_q + 1'b1;
      end else if (pop_young) begin
        tail_q <= step_dn(tail_q);
        cnt_q  <= cnt_q - 1'b1;
      end else if (pop_old) begin
        head_q <= step_up(head_q);
        cnt_q  <= cnt_q - 1'b1;
      end
    end
  end

  // R3: occupancy never passes the capacity
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);
  // R9: removals only from a non-empty log
  assert_no_pop_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_young || pop_old) |-> !empty);
  // R9: a write and a removal never share a cycle
  assert_single_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({push, pop_young, pop_old}));
endmodule

// File: rtl/rhl_walker.sv
module rhl_walker
  import rhl_pkg::*;
#(
  parameter int SEQ_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sq_valid,
  input  logic [SEQ_W-1:0] sq_seq,
  input  logic [SEQ_W-1:0] done_seq,
  input  logic             thread_squashing,
  input  logic             empty,
  input  logic [SEQ_W-1:0] young_seq,
  input  logic [SEQ_W-1:0] old_seq,
  output logic             busy,
  output logic             pop_young,
  output logic             pop_old
);
  walk_e            state_q;
  logic [SEQ_W-1:0] bound_q;
  logic             commit_ok;

  assign busy      = (state_q != WALK_IDLE);
  assign commit_ok = (done_seq != '0) && !thread_squashing;
  assign pop_young = (state_q == WALK_UNDO)   && !empty && (young_seq > bound_q);
  assign pop_old   = (state_q == WALK_RETIRE) && !empty && (old_seq <= bound_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= WALK_IDLE;
      bound_q <= '0;
    end else begin
      unique case (state_q)
        WALK_IDLE: begin
          if (sq_valid) begin
            state_q <= WALK_UNDO;
            bound_q <= sq_seq;
          end else if (commit_ok) begin
            state_q <= WALK_RETIRE;
            bound_q <= done_seq;
          end
        end
        WALK_UNDO:   if (!pop_young) state_q <= WALK_IDLE;
        WALK_RETIRE: if (!pop_old)   state_q <= WALK_IDLE;
        default:     state_q <= WALK_IDLE;
      endcase
    end
  end

  // R7: a commit never starts alongside a squash or while the thread squashes
  assert_commit_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (sq_valid || thread_squashing)) |=> (state_q != WALK_RETIRE));
  // R9: a walk begins only from an idle cycle that carried a request
  assert_walk_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(sq_valid || done_seq != '0));
  // R4: squash takes priority over commit
  assert_squash_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && sq_valid) |=> (state_q == WALK_UNDO));
endmodule

// File: rtl/rhl_release.sv
module rhl_release #(
  parameter int AREG_W        = 6,
  parameter int PREG_W        = 7,
  parameter int NONMISC_PREGS = 96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              undo_pop,
  input  logic              retire_pop,
  input  logic [AREG_W-1:0] young_areg,
  input  logic [PREG_W-1:0] young_new,
  input  logic [PREG_W-1:0] young_prev,
  input  logic [PREG_W-1:0] old_prev,
  output logic              map_wr_valid,
  output logic [AREG_W-1:0] map_wr_areg,
  output logic [PREG_W-1:0] map_wr_preg,
  output logic              free_valid,
  output logic [PREG_W-1:0] free_preg,
  output logic              sb_set_valid,
  output logic [PREG_W-1:0] sb_set_preg
);
  localparam int PREG_SPAN = 1 << PREG_W;

  logic is_misc;

  generate
    if (NONMISC_PREGS < PREG_SPAN) begin : g_misc_cmp
      assign is_misc = (young_new >= PREG_W'(NONMISC_PREGS));
    end else begin : g_no_misc
      assign is_misc = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      map_wr_valid <= 1'b0;
      map_wr_areg  <= '0;
      map_wr_preg  <= '0;
      free_valid   <= 1'b0;
      free_preg    <= '0;
      sb_set_valid <= 1'b0;
      sb_set_preg  <= '0;
    end else begin
      map_wr_valid <= undo_pop;
      free_valid   <= undo_pop || retire_pop;
      sb_set_valid <= undo_pop && is_misc;
      if (undo_pop) begin
        map_wr_areg <= young_areg;
        map_wr_preg <= young_prev;
        free_preg   <= young_new;
        sb_set_preg <= young_new;
      end else if (retire_pop) begin
        free_preg <= old_prev;
      end
    end
  end

  // R5: a scoreboard set always rides with the matching map write
  assert_sb_with_map_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sb_set_valid |-> (map_wr_valid && free_valid && sb_set_preg == free_preg));
  // R5: only miscellaneous-range registers are marked ready
  assert_sb_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sb_set_valid |-> (int'(sb_set_preg) >= NONMISC_PREGS));
  // R6: a retirement return carries no map write
  assert_retire_no_map_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(retire_pop) |-> (free_valid && !map_wr_valid && !sb_set_valid));
  // R4: every map restore comes with a free-list return
  assert_undo_pairs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    map_wr_valid |-> free_valid);
endmodule

// File: rtl/rename_history_log.sv
module rename_history_log #(
  parameter int DEPTH         = 16,
  parameter int SEQ_W         = 16,
  parameter int AREG_W        = 6,
  parameter int PREG_W        = 7,
  parameter int NONMISC_PREGS = 96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rec_valid,
  output logic              rec_ready,
  input  logic [SEQ_W-1:0]  rec_seq,
  input  logic [AREG_W-1:0] rec_areg,
  input  logic [PREG_W-1:0] rec_new_preg,
  input  logic [PREG_W-1:0] rec_prev_preg,
  input  logic              sq_valid,
  input  logic [SEQ_W-1:0]  sq_seq,
  input  logic [SEQ_W-1:0]  done_seq,
  input  logic              thread_squashing,
  output logic              busy,
  output logic              overflow,
  output logic              map_wr_valid,
  output logic [AREG_W-1:0] map_wr_areg,
  output logic [PREG_W-1:0] map_wr_preg,
  output logic              free_valid,
  output logic [PREG_W-1:0] free_preg,
  output logic              sb_set_valid,
  output logic [PREG_W-1:0] sb_set_preg
);
  logic              rec_fire, log_full, log_empty, pop_young, pop_old;
  logic [SEQ_W-1:0]  young_seq, old_seq;
  logic [AREG_W-1:0] young_areg;
  logic [PREG_W-1:0] young_new, young_prev, old_prev;

  assign rec_ready = !busy;
  assign rec_fire  = rec_valid && rec_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) overflow <= 1'b0;
    else        overflow <= rec_fire && log_full;
  end

  rhl_ring #(
    .DEPTH(DEPTH), .SEQ_W(SEQ_W), .AREG_W(AREG_W), .PREG_W(PREG_W)
  ) ring_i (
    .clk(clk), .rst_n(rst_n),
    .push(rec_fire), .push_seq(rec_seq), .push_areg(rec_areg),
    .push_new(rec_new_preg), .push_prev(rec_prev_preg),
    .pop_young(pop_young), .pop_old(pop_old),
    .full(log_full), .empty(log_empty),
    .young_seq(young_seq), .young_areg(young_areg),
    .young_new(young_new), .young_prev(young_prev),
    .old_seq(old_seq), .old_prev(old_prev)
  );

  rhl_walker #(.SEQ_W(SEQ_W)) walker_i (
    .clk(clk), .rst_n(rst_n),
    .sq_valid(sq_valid), .sq_seq(sq_seq), .done_seq(done_seq),
    .thread_squashing(thread_squashing), .empty(log_empty),
    .young_seq(young_seq), .old_seq(old_seq),
    .busy(busy), .pop_young(pop_young), .pop_old(pop_old)
  );

  rhl_release #(
    .AREG_W(AREG_W), .PREG_W(PREG_W), .NONMISC_PREGS(NONMISC_PREGS)
  ) release_i (
    .clk(clk), .rst_n(rst_n),
    .undo_pop(pop_young), .retire_pop(pop_old),
    .young_areg(young_areg), .young_new(young_new),
    .young_prev(young_prev), .old_prev(old_prev),
    .map_wr_valid(map_wr_valid), .map_wr_areg(map_wr_areg),
    .map_wr_preg(map_wr_preg), .free_valid(free_valid),
    .free_preg(free_preg), .sb_set_valid(sb_set_valid),
    .sb_set_preg(sb_set_preg)
  );

  // R3: an overflow pulse follows an offered record into a full log
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> $past(rec_valid && log_full && !busy));
  // R9: release strobes only appear while a walk is still open
  assert_strobe_in_walk_R9: assert property (@(posedge clk) disable iff (!rst_n)
    free_valid |-> busy);
  // R8: an empty log ends any walk at once
  assert_empty_walk_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && log_empty) |=> !busy);
endmodule

// File: tb/rename_history_log_tb.sv
module rename_history_log_tb_top;
  localparam int DEPTH = 16, SEQ_W = 16, AREG_W = 6, PREG_W = 7, NONMISC = 96;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rec_valid = 0, sq_valid = 0, thread_squashing = 0;
  logic [SEQ_W-1:0] rec_seq = '0, sq_seq = '0, done_seq = '0;
  logic [AREG_W-1:0] rec_areg = '0;
  logic [PREG_W-1:0] rec_new_preg = '0, rec_prev_preg = '0;
  logic rec_ready, busy, overflow, map_wr_valid, free_valid, sb_set_valid;
  logic [AREG_W-1:0] map_wr_areg;
  logic [PREG_W-1:0] map_wr_preg, free_preg, sb_set_preg;

  always #5 clk = ~clk;

  rename_history_log #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .AREG_W(AREG_W),
    .PREG_W(PREG_W), .NONMISC_PREGS(NONMISC)) dut_i (.*);

  typedef struct packed {
    logic [SEQ_W-1:0] seq; logic [AREG_W-1:0] areg;
    logic [PREG_W-1:0] newp; logic [PREG_W-1:0] prevp;
  } ent_t;
  typedef struct packed {
    logic mv; logic [AREG_W-1:0] ma; logic [PREG_W-1:0] mp;
    logic fv; logic [PREG_W-1:0] fp; logic sv; logic [PREG_W-1:0] sp;
  } ev_t;

  ent_t  mdl[$];
  ev_t   expq[$];
  string tagq[$];
  int n_chk = 0, n_bad = 0, walk_k = 0, busy_cnt = 0;
  bit exp_ovf = 0, walk_on = 0, finished = 0;
  logic [SEQ_W-1:0] cur_seq = 16'd20;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic ev_t obs_ev();
    ev_t o;
    o.mv = map_wr_valid; o.ma = map_wr_valid ? map_wr_areg : '0;
    o.mp = map_wr_valid ? map_wr_preg : '0;
    o.fv = free_valid;   o.fp = free_valid ? free_preg : '0;
    o.sv = sb_set_valid; o.sp = sb_set_valid ? sb_set_preg : '0;
    return o;
  endfunction

  function automatic void model_squash(logic [SEQ_W-1:0] s);
    int k = 0;
    while (mdl.size() != 0 && mdl[$].seq > s) begin
      ent_t e = mdl.pop_back();
      ev_t v;
      bit misc = (int'(e.newp) >= NONMISC);
      v.mv = 1; v.ma = e.areg; v.mp = e.prevp; v.fv = 1; v.fp = e.newp;
      v.sv = misc; v.sp = misc ? e.newp : '0;
      expq.push_back(v); tagq.push_back(misc ? "R5" : "R4");
      k++;
    end
    walk_on = 1; walk_k = k; busy_cnt = 0;
  endfunction

  function automatic void model_commit(logic [SEQ_W-1:0] d);
    int k = 0;
    while (mdl.size() != 0 && mdl[0].seq <= d) begin
      ent_t e = mdl.pop_front();
      ev_t v = '0;
      v.fv = 1; v.fp = e.prevp;
      expq.push_back(v); tagq.push_back("R6");
      k++;
    end
    walk_on = 1; walk_k = k; busy_cnt = 0;
  endfunction

  task automatic observe();
    ev_t o = obs_ev();
    if (o.mv || o.fv || o.sv) begin
      if (expq.size() == 0) chk(0, "R9", "unexpected strobe", longint'(o), 0);
      else begin
        ev_t e = expq.pop_front();
        string t = tagq.pop_front();
        chk(o == e, t, "release strobe", longint'(o), longint'(e));
      end
    end
    chk(overflow == exp_ovf, "R3", "overflow pulse", overflow, exp_ovf);
    exp_ovf = 0;
    chk(rec_ready == !busy, "R2", "rec_ready vs busy", rec_ready, !busy);
    if (walk_on) begin
      if (busy) busy_cnt++;
      else begin
        chk(busy_cnt == walk_k + 1, (walk_k == 0) ? "R8" : "R9", "walk length",
            busy_cnt, walk_k + 1);
        chk(expq.size() == 0, "R9", "strobes missing", expq.size(), 0);
        walk_on = 0;
      end
    end else begin
      chk(!busy, "R7", "busy with no accepted request", busy, 0);
    end
  endtask

  task automatic cyc(bit rv, logic [SEQ_W-1:0] s, logic [AREG_W-1:0] a,
                     logic [PREG_W-1:0] np, logic [PREG_W-1:0] pp, bit sv,
                     logic [SEQ_W-1:0] ss, logic [SEQ_W-1:0] d, bit sqi);
    @(negedge clk);
    observe();
    rec_valid = rv; rec_seq = s; rec_areg = a; rec_new_preg = np; rec_prev_preg = pp;
    sq_valid = sv; sq_seq = ss; done_seq = d; thread_squashing = sqi;
    if (!busy) begin
      if (rv) begin
        if (mdl.size() == DEPTH) exp_ovf = 1;
        else mdl.push_back('{seq: s, areg: a, newp: np, prevp: pp});
      end
      if (sv) model_squash(ss);
      else if (d != 0 && !sqi) model_commit(d);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic rec(logic [SEQ_W-1:0] s, logic [AREG_W-1:0] a,
                     logic [PREG_W-1:0] np, logic [PREG_W-1:0] pp);
    cyc(1, s, a, np, pp, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R9 watchdog expired: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4177));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    chk(!busy && rec_ready && !overflow && !map_wr_valid && !free_valid && !sb_set_valid,
        "R1", "reset state", {busy, rec_ready, overflow, map_wr_valid, free_valid, sb_set_valid},
        6'b010000);
    // R8: walks on an empty log
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0); idle(3);
    cyc(0, 0, 0, 0, 0, 0, 0, 16'd5, 0); idle(3);
    // R7: zero done number and blocked commit are ignored
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
    rec(16'd3, 6'd1, 7'd40, 7'd1);
    cyc(0, 0, 0, 0, 0, 0, 0, 16'd9, 1); idle(2);
    cyc(0, 0, 0, 0, 0, 0, 0, 16'd3, 0); idle(4);
    // R2, R4, R5, R6: shared sequence numbers and a misc register
    rec(16'd10, 6'd2, 7'd50, 7'd2);  rec(16'd10, 6'd3, 7'd51, 7'd3);
    rec(16'd11, 6'd4, 7'd100, 7'd4); rec(16'd12, 6'd5, 7'd52, 7'd5);
    rec(16'd13, 6'd6, 7'd127, 7'd6);
    cyc(0, 0, 0, 0, 0, 1, 16'd10, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 16'd0, 16'd10, 0);  // R9: ignored while busy
    idle(6);
    cyc(0, 0, 0, 0, 0, 0, 0, 16'd10, 0); idle(5);
    // R7: squash and commit together, only the squash runs
    rec(16'd14, 6'd7, 7'd60, 7'd7); rec(16'd15, 6'd8, 7'd61, 7'd8);
    cyc(0, 0, 0, 0, 0, 1, 16'd14, 16'd15, 0); idle(4);
    // R3: fill and overflow, then drain
    for (int i = 0; i < DEPTH + 2; i++) rec(16'd20 + 16'(i), 6'(i), 7'(i + 90), 7'(i));
    idle(2);
    cyc(0, 0, 0, 0, 0, 0, 0, 16'hFFFF, 0); idle(DEPTH + 4);
    // constrained random traffic
    cur_seq = 16'd100;
    for (int i = 0; i < 4000; i++) begin
      bit rv = ($urandom % 10) < 6;
      bit sv = ($urandom % 100) < 5;
      bit cv = ($urandom % 100) < 8;
      bit sqi = ($urandom % 10) == 0;
      logic [SEQ_W-1:0] ss = cur_seq - 16'($urandom % 10);
      logic [SEQ_W-1:0] d = cv ? cur_seq - 16'($urandom % 12) : '0;
      if (($urandom % 3) == 0) cur_seq = cur_seq + 1'b1;
      cyc(rv, cur_seq, 6'($urandom), 7'($urandom), 7'($urandom), sv, ss, d, sqi);
    end
    idle(DEPTH + 6);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule